// File: doc/BRIEF.md
# DMA Transaction Identifier Tracker

This block gives out ordered transaction identifiers to descriptors as they are submitted to a DMA channel. It keeps two pointers: the identifier handed out most recently (issued) and the identifier the data mover most recently finished (completed). It answers status queries about any identifier. Identifiers are signed values, 32 bits wide by default. A valid identifier is strictly positive, and a value of zero or below stands for an error code. When the issued counter reaches the largest positive value, the next identifier is 1. A query is therefore judged on a circular identifier space, and the answer stays correct after the issued pointer has wrapped past the completed pointer.

A submitter pulses `sub_valid_i`. One cycle later the new identifier appears on `sub_id_o` together with `sub_resp_o`. The data mover reports each finished descriptor on `done_valid_i` / `done_id_i`. It can also flag that the transfer in flight is paused (`pause_i`) or has failed (`err_i`). A query on `qry_valid_i` / `qry_id_i` is answered one cycle later. The answer holds a 2-bit status, the completed and issued pointers, and a residue byte count. The residue is taken from the data mover when residue reporting is enabled.

Top module: `cookie_tracker`

## Requirements
- R1: After reset, the first submission receives identifier 1. Every identifier handed out is strictly positive. `sub_resp_o` is high in the cycle after each `sub_valid_i` and low otherwise.
- R2: Each submission receives the identifier one above the one before. After the largest positive value (2^(ID_W-1)-1), the next identifier is 1. Zero and negative values are never handed out.
- R3: A completion pulse sets the completed pointer to `done_id_i`. Each query answer reports the completed pointer on `qry_last_o` and the issued pointer on `qry_used_o`.
- R4: When completed <= issued (signed), a queried positive identifier is complete if it is <= completed or > issued. Otherwise it is in progress.
- R5: When completed > issued (the issued pointer has wrapped), a queried positive identifier is complete only if it is <= completed and > issued. Otherwise it is in progress.
- R6: A query is judged on the pointers and error state as they stand after any submission, completion or error pulse that arrives in the same cycle.
- R7: Status codes are 0 complete, 1 in progress, 2 paused and 3 error. A queried identifier of zero or below always answers 3.
- R8: The in-flight identifier is completed+1, or 1 when completed is the largest positive value. While `pause_i` is high, a query of the in-flight identifier that would answer in progress answers paused instead.
- R9: An `err_i` pulse latches error for the in-flight identifier. Queries of that identifier then answer 3 until the next submission clears the latch. A submission and an error pulse in the same cycle leave the latch set.
- R10: With residue reporting enabled, a query answering in progress or paused for the in-flight identifier returns `residue_i` on `qry_residue_o`. Every other answer carries residue 0, and all answers carry 0 when residue reporting is disabled.
- R11: Reset clears both pointers to 0 and clears the error latch. Until the first submission, every positive identifier reports complete. Both response strobes are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_valid_i | input | 1 | Submission request |
| sub_resp_o | output | 1 | Submission answered, one cycle after the request |
| sub_id_o | output | ID_W | Identifier assigned to the submission |
| done_valid_i | input | 1 | Data mover finished a descriptor |
| done_id_i | input | ID_W | Identifier of the finished descriptor |
| pause_i | input | 1 | The in-flight transfer is paused |
| err_i | input | 1 | The in-flight transfer failed |
| residue_i | input | RES_W | Bytes remaining on the in-flight transfer |
| qry_valid_i | input | 1 | Status query request |
| qry_id_i | input | ID_W | Identifier being queried |
| qry_resp_o | output | 1 | Query answered, one cycle after the request |
| qry_status_o | output | 2 | 0 complete, 1 in progress, 2 paused, 3 error |
| qry_last_o | output | ID_W | Completed pointer |
| qry_used_o | output | ID_W | Issued pointer |
| qry_residue_o | output | RES_W | Remaining bytes, or 0 |

## Verification
A corrupted issued pointer shows on the very next submission response, as a skipped or repeated identifier. It also shows on `qry_used_o` in the next query answer. A wrong completed pointer or a mishandled wrap comparison flips the status of identifiers near the wrap boundary from complete to in progress, or the other way round. A narrow identifier width lets the stimulus wrap the space several times, so both comparison cases are exercised. A stale error latch or a wrong in-flight identifier shows within one query, as an error or paused answer on the wrong identifier or as an unexpected residue value.

// File: rtl/cookie_pkg.sv
package cookie_pkg;
    typedef enum logic [1:0] {
        ST_DONE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_PAUSED = 2'd2,
        ST_FAULT  = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/cookie_alloc.sv
// Issued-identifier counter: hands out the next positive identifier per submission.
module cookie_alloc #(
    parameter int ID_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            take_i,
    output logic [ID_W-1:0] cur_o,
    output logic [ID_W-1:0] nxt_o,
    output logic            resp_o
);
    localparam logic [ID_W-1:0] MAX_ID = {1'b0, {(ID_W-1){1'b1}}};
    localparam logic [ID_W-1:0] MIN_ID = {{(ID_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0] issued;
        logic            resp;
    } alloc_t;

    alloc_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.resp = take_i;
        if (take_i) begin
            if ((st_q.issued == MAX_ID) || ($signed(st_q.issued) < $signed(MIN_ID)))
                st_d.issued = MIN_ID;
            else
                st_d.issued = st_q.issued + MIN_ID;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_o  = st_q.issued;
    assign nxt_o  = st_d.issued;
    assign resp_o = st_q.resp;

    // R1: every handed-out identifier is positive
    a_r1_id_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_o |-> ($signed(cur_o) > 0));
    // R2: consecutive identifiers, or restart at 1
    a_r2_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> ((cur_o == MIN_ID) || (cur_o == $past(cur_o) + MIN_ID)));
    // R2: no change without a submission
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(cur_o));
endmodule

// File: rtl/cookie_judge.sv
// Circular completion decision on the identifier space.
module cookie_judge #(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0] comp_i,
    input  logic [ID_W-1:0] iss_i,
    input  logic [ID_W-1:0] qid_i,
    output logic            legal_o,
    output logic            done_o
);
    logic signed [ID_W-1:0] c_s, u_s, q_s;
    logic                   below_c, above_u;

    always_comb begin
        c_s     = $signed(comp_i);
        u_s     = $signed(iss_i);
        q_s     = $signed(qid_i);
        legal_o = (q_s > 0);
        below_c = (q_s <= c_s);
        above_u = (q_s > u_s);
        if (c_s <= u_s) done_o = below_c || above_u;   // R4
        else            done_o = below_c && above_u;   // R5
    end
endmodule

// File: rtl/cookie_tracker.sv
module cookie_tracker #(
    parameter int ID_W        = 32,
    parameter int RES_W       = 32,
    parameter bit HAS_RESIDUE = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sub_valid_i,
    output logic             sub_resp_o,
    output logic [ID_W-1:0]  sub_id_o,
    input  logic             done_valid_i,
    input  logic [ID_W-1:0]  done_id_i,
    input  logic             pause_i,
    input  logic             err_i,
    input  logic [RES_W-1:0] residue_i,
    input  logic             qry_valid_i,
    input  logic [ID_W-1:0]  qry_id_i,
    output logic             qry_resp_o,
    output logic [1:0]       qry_status_o,
    output logic [ID_W-1:0]  qry_last_o,
    output logic [ID_W-1:0]  qry_used_o,
    output logic [RES_W-1:0] qry_residue_o
);
    import cookie_pkg::*;

    localparam logic [ID_W-1:0] MAX_ID = {1'b0, {(ID_W-1){1'b1}}};
    localparam logic [ID_W-1:0] MIN_ID = {{(ID_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0]  comp;
        logic             err_vld;
        logic [ID_W-1:0]  err_id;
        logic             q_resp;
        xfer_state_e      q_status;
        logic [ID_W-1:0]  q_last;
        logic [ID_W-1:0]  q_used;
        logic [RES_W-1:0] q_res;
    } trk_t;

    trk_t st_d, st_q;

    logic [ID_W-1:0]  iss_cur, iss_nxt, inflight;
    logic             q_legal, q_done;
    logic [RES_W-1:0] res_src;

    cookie_alloc #(.ID_W(ID_W)) u_alloc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .take_i (sub_valid_i),
        .cur_o  (iss_cur),
        .nxt_o  (iss_nxt),
        .resp_o (sub_resp_o)
    );

    cookie_judge #(.ID_W(ID_W)) u_judge (
        .comp_i  (st_d.comp),
        .iss_i   (iss_nxt),
        .qid_i   (qry_id_i),
        .legal_o (q_legal),
        .done_o  (q_done)
    );

    generate
        if (HAS_RESIDUE) begin : g_res
            assign res_src = residue_i;
        end else begin : g_nores
            assign res_src = '0;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.q_resp = qry_valid_i;
        // R3, R6: completion updates the pointer used by the same-cycle query
        if (done_valid_i) st_d.comp = done_id_i;
        inflight = (st_d.comp == MAX_ID) ? MIN_ID : (st_d.comp + MIN_ID);
        // R9: submission clears the latch, error sets it
        if (sub_valid_i) st_d.err_vld = 1'b0;
        if (err_i) begin
            st_d.err_vld = 1'b1;
            st_d.err_id  = inflight;
        end
        if (qry_valid_i) begin
            st_d.q_last = st_d.comp;
            st_d.q_used = iss_nxt;
            st_d.q_res  = '0;
            if (!q_legal)
                st_d.q_status = ST_FAULT;
            else if (st_d.err_vld && (qry_id_i == st_d.err_id))
                st_d.q_status = ST_FAULT;
            else if (q_done)
                st_d.q_status = ST_DONE;
            else if (pause_i && (qry_id_i == inflight))
                st_d.q_status = ST_PAUSED;
            else
                st_d.q_status = ST_BUSY;
            if (((st_d.q_status == ST_BUSY) || (st_d.q_status == ST_PAUSED)) &&
                (qry_id_i == inflight))
                st_d.q_res = res_src;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sub_id_o      = iss_cur;
    assign qry_resp_o    = st_q.q_resp;
    assign qry_status_o  = st_q.q_status;
    assign qry_last_o    = st_q.q_last;
    assign qry_used_o    = st_q.q_used;
    assign qry_residue_o = st_q.q_res;

    // R1: response one cycle after each submission
    a_r1_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_valid_i |=> sub_resp_o);
    // R7: non-positive query identifiers answer error
    a_r7_bad_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qry_valid_i && ($signed(qry_id_i) <= 0)) |=> (qry_status_o == 2'd3));
    // R8: paused only while pause was requested
    a_r8_pause_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qry_resp_o && (qry_status_o == 2'd2)) |-> $past(pause_i));
    // R10: complete answers never carry residue
    a_r10_done_nores: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qry_resp_o && (qry_status_o == 2'd0)) |-> (qry_residue_o == '0));
    // R3: completion pointer reported by the next query
    a_r3_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qry_valid_i && done_valid_i) |=> (qry_last_o == $past(done_id_i)));
endmodule

// File: tb/test_cookie_tracker.sv
module test_cookie_tracker;
    localparam int ID_W  = 8;
    localparam int RES_W = 16;
    localparam int M     = 127;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sub_valid = 1'b0;
    logic             sub_resp;
    logic [ID_W-1:0]  sub_id;
    logic             done_valid = 1'b0;
    logic [ID_W-1:0]  done_id = '0;
    logic             pause = 1'b0;
    logic             err = 1'b0;
    logic [RES_W-1:0] residue = '0;
    logic             qry_valid = 1'b0;
    logic [ID_W-1:0]  qry_id = '0;
    logic             qry_resp;
    logic [1:0]       qry_status;
    logic [ID_W-1:0]  qry_last, qry_used;
    logic [RES_W-1:0] qry_residue;

    int checks = 0;
    int fails  = 0;
    int nsub = 0, ncomp = 0, errid = 0;
    bit errv = 0;

    always #4 clk = ~clk;

    cookie_tracker #(.ID_W(ID_W), .RES_W(RES_W), .HAS_RESIDUE(1'b1)) i_cookie_tracker (
        .clk_i(clk), .rst_ni(rst_n),
        .sub_valid_i(sub_valid), .sub_resp_o(sub_resp), .sub_id_o(sub_id),
        .done_valid_i(done_valid), .done_id_i(done_id),
        .pause_i(pause), .err_i(err), .residue_i(residue),
        .qry_valid_i(qry_valid), .qry_id_i(qry_id),
        .qry_resp_o(qry_resp), .qry_status_o(qry_status),
        .qry_last_o(qry_last), .qry_used_o(qry_used), .qry_residue_o(qry_residue)
    );

    function automatic int idof(int n);
        return (n == 0) ? 0 : ((n - 1) % M) + 1;
    endfunction

    function automatic bit outstanding(int q);
        for (int n = ncomp + 1; n <= nsub; n++)
            if (idof(n) == q) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check after the next rising edge.
    task automatic cycle(bit s, int k, bit e, bit p, bit qv, int q, int res);
        int  est, eres, inflight;
        bit  wrapped;
        string stag;
        sub_valid = s; err = e; pause = p; qry_valid = qv;
        qry_id = q[ID_W-1:0]; residue = res[RES_W-1:0];
        if (s) begin nsub++; errv = 0; end
        if (k > 0 && ncomp + k <= nsub) begin
            ncomp += k; done_valid = 1'b1; done_id = idof(ncomp)[ID_W-1:0];
        end else begin
            done_valid = 1'b0;
        end
        inflight = idof(ncomp + 1);
        if (e) begin errv = 1; errid = inflight; end
        wrapped = idof(ncomp) > idof(nsub);
        stag = wrapped ? "R5" : "R4";
        eres = 0;
        if (q <= 0) begin est = 3; stag = "R7"; end
        else if (errv && q == errid) begin est = 3; stag = "R9"; end
        else if (!outstanding(q)) est = 0;
        else if (p && q == inflight) begin est = 2; stag = "R8"; end
        else est = 1;
        if ((est == 1 || est == 2) && q == inflight) eres = res;
        if (qv && (s || done_valid)) stag = {stag, "/R6"};
        @(negedge clk);
        chk(sub_resp == s, "R1 sub_resp", int'(sub_resp), int'(s));
        if (s) chk(sub_id == idof(nsub)[ID_W-1:0], "R2 sub_id", int'(sub_id), idof(nsub));
        chk(qry_resp == qv, "R3 qry_resp", int'(qry_resp), int'(qv));
        if (qv) begin
            chk(int'(qry_status) == est, stag, int'(qry_status), est);
            chk(qry_last == idof(ncomp)[ID_W-1:0], "R3 last", int'(qry_last), idof(ncomp));
            chk(qry_used == idof(nsub)[ID_W-1:0], "R3 used", int'(qry_used), idof(nsub));
            chk(qry_residue == eres[RES_W-1:0], "R10 residue", int'(qry_residue), eres);
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int r, q, k;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk(sub_resp == 1'b0, "R11 sub_resp", int'(sub_resp), 0);
        chk(qry_resp == 1'b0, "R11 qry_resp", int'(qry_resp), 0);
        cycle(0, 0, 0, 0, 1, 5, 7);      // R11: positive id complete before any submit
        cycle(0, 0, 0, 0, 1, 127, 7);    // R11
        cycle(0, 0, 0, 0, 1, 0, 7);      // R7: zero id
        cycle(0, 0, 0, 0, 1, -3, 7);     // R7: negative id
        cycle(1, 0, 0, 0, 1, 1, 9);      // R1/R6: first id is 1, in progress at once
        cycle(0, 0, 0, 1, 1, 1, 11);     // R8: paused in-flight
        cycle(1, 0, 1, 0, 1, 1, 3);      // R9: error and submit same cycle keeps latch
        cycle(1, 0, 0, 0, 1, 1, 3);      // R9: next submit clears
        cycle(0, 3, 0, 0, 1, 2, 3);      // R3: completion
        // Random traffic wraps the 7-bit positive space many times (R2, R4, R5)
        for (int i = 0; i < 4000; i++) begin
            r = $urandom % 3;
            k = (nsub > ncomp) ? int'($urandom % 4) : 0;
            if (r == 0) q = idof(ncomp + 1);
            else if (r == 1) q = idof(ncomp + int'($urandom % 8));
            else q = int'($urandom % 256) - 128;
            cycle((nsub - ncomp < 100) && ($urandom % 2 == 0), k,
                  ($urandom % 16) == 0, ($urandom % 4) == 0,
                  ($urandom % 4) != 0, q, int'($urandom % 65536));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule